// File: doc/BRIEF.md
# Instruction Pointer and Stack Sequencer

This block is the control-flow engine of a small 8-bit processor with a 256-byte address space. It owns the instruction pointer, the stack pointer and the interrupt-enable bit. It takes one decoded instruction at a time through a valid/ready pair. For control instructions it works out the next instruction pointer itself: relative jumps, calls, returns and software interrupts. For every other instruction it advances the pointer by a length that the decoder supplies.

All stack traffic goes through one memory port, and a read returns its data one cycle after it is issued. Calls, software interrupts and pushes store a byte at the stack pointer and then move the pointer down. Returns and pops move the pointer up and then read. A popped byte comes back on a result strobe, with a marker that says whether it belongs to the status register or to a general register.

A level-sensitive hardware interrupt request is taken only at an instruction boundary and only while interrupts are enabled. It saves the address of the next instruction, clears the enable bit and jumps through the vector stored at memory address 02. A halt instruction freezes the sequencer until reset.

Top module: `flow_seq`

## Requirements
- R1: After reset, `ip` is 00, `sp` is BF, `int_en` is 0, `halted` is 0 and `op_ready` is 1.
- R2: Code C0 adds `op_arg`, read as a signed two's-complement byte, to `ip` (FE steps back by 2, 7F forward by 127).
- R3: Codes C1/C2 test Z, C3/C4 test S and C5/C6 test O. The odd code jumps when its flag is 1 and the even code jumps when it is 0. A taken jump adds the signed `op_arg` to `ip`; an untaken one adds 2.
- R4: Code CA writes `ip`+2 to memory at `sp`, decrements `sp` and loads `ip` with `op_arg`.
- R5: Codes CB (return) and CD (interrupt return) increment `sp`, read memory at the new `sp` and load `ip` from it. `int_en` is left unchanged.
- R6: Code CC writes `ip`+2 at `sp` and decrements `sp`. It then reads memory at address `op_arg` and loads `ip` from that byte; `int_en` is unchanged.
- R7: Code E0 writes `push_data` at `sp`, decrements `sp` and advances `ip` by 2. Code EA writes `status_in` the same way and advances `ip` by 1.
- R8: Codes E1 and EB increment `sp` and read memory there. In the following cycle `pop_valid` is 1 and `pop_data` carries the byte. `pop_flags` is 0 for E1 and 1 for EB; `ip` advances by 2 for E1 and by 1 for EB.
- R9: Code FC sets `int_en` and FD clears it. FC, FD and FF advance `ip` by 1. Any code outside the control set advances `ip` by `op_len`.
- R10: While `int_en` is 1 and no instruction is in progress, `irq` high pulls `op_ready` low. The block then writes the current `ip` at `sp`, decrements `sp`, clears `int_en` and loads `ip` from memory address 02. While `int_en` is 0, `irq` has no effect.
- R11: Code 00 sets `halted`. From then on `ip`, `sp` and `int_en` hold, `op_ready` stays 0, and `irq` is ignored until reset.
- R12: `ip` and `sp` wrap modulo 256.
- R13: The block never reads and writes memory in the same cycle. `op_ready` is 0 in every cycle of a multi-cycle instruction after the one in which it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A decoded instruction is presented |
| op_ready | output | 1 | Instruction accepted this cycle if valid |
| op_code | input | 8 | Opcode byte |
| op_arg | input | 8 | Operand byte (displacement, target or vector address) |
| op_len | input | 2 | Length of a non-control instruction |
| flag_z | input | 1 | Zero flag from the ALU |
| flag_s | input | 1 | Sign flag from the ALU |
| flag_o | input | 1 | Overflow flag from the ALU |
| push_data | input | 8 | Register value stored by a push |
| status_in | input | 8 | Status register value stored by a flag push |
| irq | input | 1 | Hardware interrupt request, level |
| mem_addr | output | 8 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data one cycle later |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| pop_valid | output | 1 | Popped byte is present |
| pop_flags | output | 1 | Popped byte is for the status register |
| pop_data | output | 8 | Popped byte |
| ip | output | 8 | Instruction pointer |
| sp | output | 8 | Stack pointer |
| int_en | output | 1 | Interrupt enable |
| halted | output | 1 | Sequencer is halted |

## Verification
The hardest case to reach is a hardware interrupt that arrives on the same edge at which an enable instruction completes. The enable bit only exists inside the block, so the stimulus holds `irq` high while the enable is 0, issues a plain instruction to show that nothing happens, and then issues the enable instruction with the request still high. The bench expects the next-instruction address on the stack, the vector from address 02 in `ip` and the enable bit cleared. A second hard case is the stack pointer wrapping: the bench pushes 193 bytes from reset so that `sp` passes through 00, then pops them all back and checks the order. Jumps are swept over all 256 displacements and every flag combination for each conditional code.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

   localparam logic [7:0] OPC_HALT  = 8'h00;
   localparam logic [7:0] OPC_JMP   = 8'hC0;
   localparam logic [7:0] OPC_CALL  = 8'hCA;
   localparam logic [7:0] OPC_RET   = 8'hCB;
   localparam logic [7:0] OPC_INT   = 8'hCC;
   localparam logic [7:0] OPC_IRET  = 8'hCD;
   localparam logic [7:0] OPC_PUSH  = 8'hE0;
   localparam logic [7:0] OPC_POP   = 8'hE1;
   localparam logic [7:0] OPC_PUSHF = 8'hEA;
   localparam logic [7:0] OPC_POPF  = 8'hEB;
   localparam logic [7:0] OPC_STI   = 8'hFC;
   localparam logic [7:0] OPC_CLI   = 8'hFD;
   localparam logic [7:0] OPC_NOP   = 8'hFF;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_RETLD,
      ST_VECRD,
      ST_VECLD,
      ST_POPRD,
      ST_HALT
   } seq_state_t;

endpackage

// File: rtl/flow_seq_branch.sv
module flow_seq_branch
   import flow_seq_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic [7:0]    code,
   input  logic [DW-1:0] disp,
   input  logic          fz,
   input  logic          fs,
   input  logic          fo,
   input  logic [AW-1:0] cur_ip,
   output logic          is_branch,
   output logic [AW-1:0] next_ip
);
   localparam int NPAIR = 3;
   localparam int NCODE = 2 * NPAIR + 1;
   localparam logic [AW-1:0] STEP2 = AW'(2);

   logic [NPAIR-1:0] flv;
   logic [NCODE-1:0] hit_v;
   logic [NCODE-1:0] take_v;
   logic             taken;

   assign flv = {fo, fs, fz};

   assign hit_v[0]  = (code == OPC_JMP);
   assign take_v[0] = 1'b1;

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      assign hit_v[2*k+1]  = (code == OPC_JMP + 8'(2*k+1));
      assign take_v[2*k+1] = flv[k];
      assign hit_v[2*k+2]  = (code == OPC_JMP + 8'(2*k+2));
      assign take_v[2*k+2] = ~flv[k];
   end

   assign is_branch = |hit_v;
   assign taken     = |(hit_v & take_v);
   assign next_ip   = taken ? cur_ip + disp[AW-1:0] : cur_ip + STEP2;

endmodule

// File: rtl/flow_seq_stack.sv
module flow_seq_stack #(
   parameter int AW     = 8,
   parameter int SP_RST = 'hBF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] sp,
   output logic [AW-1:0] sp_up
);
   localparam logic [AW-1:0] ONE  = AW'(1);
   localparam logic [AW-1:0] INIT = AW'(SP_RST);

   logic [AW-1:0] sp_q;

   assign sp    = sp_q;
   assign sp_up = sp_q + ONE;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sp_q <= INIT;
      else if (push)
         sp_q <= sp_q - ONE;
      else if (pop)
         sp_q <= sp_up;
   end

endmodule

// File: rtl/flow_seq.sv
module flow_seq
   import flow_seq_pkg::*;
#(
   parameter int AW     = 8,
   parameter int DW     = 8,
   parameter int IP_RST = 'h00,
   parameter int SP_RST = 'hBF,
   parameter int HW_VEC = 'h02
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   output logic          op_ready,
   input  logic [7:0]    op_code,
   input  logic [DW-1:0] op_arg,
   input  logic [1:0]    op_len,
   input  logic          flag_z,
   input  logic          flag_s,
   input  logic          flag_o,
   input  logic [DW-1:0] push_data,
   input  logic [DW-1:0] status_in,
   input  logic          irq,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic          mem_re,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          pop_valid,
   output logic          pop_flags,
   output logic [DW-1:0] pop_data,
   output logic [AW-1:0] ip,
   output logic [AW-1:0] sp,
   output logic          int_en,
   output logic          halted
);
   localparam int ASPAN = 1 << AW;
   localparam logic [AW-1:0] IP_INIT = AW'(IP_RST);
   localparam logic [AW-1:0] VEC_HW  = AW'(HW_VEC);
   localparam logic [AW-1:0] STEP1   = AW'(1);
   localparam logic [AW-1:0] STEP2   = AW'(2);

   if (AW < 2) begin : g_bad_aw
      $error("flow_seq: AW must be at least 2");
   end
   if (DW < AW) begin : g_bad_dw
      $error("flow_seq: DW must hold a full address");
   end
   if (HW_VEC >= ASPAN || SP_RST >= ASPAN || IP_RST >= ASPAN) begin : g_bad_const
      $error("flow_seq: reset or vector constant outside address space");
   end

   seq_state_t    state_q, state_d;
   logic [AW-1:0] ip_q, ip_d;
   logic [AW-1:0] vec_q, vec_d;
   logic          ien_q, ien_d;
   logic          popf_q, popf_d;
   logic          st_push, st_pop;
   logic [AW-1:0] sp_up;
   logic          is_br;
   logic [AW-1:0] br_ip;
   logic          in_run, irq_take, accept;

   flow_seq_branch #(.AW(AW), .DW(DW)) u_branch (
      .code      (op_code),
      .disp      (op_arg),
      .fz        (flag_z),
      .fs        (flag_s),
      .fo        (flag_o),
      .cur_ip    (ip_q),
      .is_branch (is_br),
      .next_ip   (br_ip)
   );

   flow_seq_stack #(.AW(AW), .SP_RST(SP_RST)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (st_push),
      .pop   (st_pop),
      .sp    (sp),
      .sp_up (sp_up)
   );

   assign in_run   = (state_q == ST_RUN);
   assign irq_take = in_run && irq && ien_q;
   assign op_ready = in_run && !irq_take;
   assign accept   = op_valid && op_ready;

   always_comb begin
      state_d   = state_q;
      ip_d      = ip_q;
      vec_d     = vec_q;
      ien_d     = ien_q;
      popf_d    = popf_q;
      st_push   = 1'b0;
      st_pop    = 1'b0;
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_addr  = sp;
      mem_wdata = '0;
      case (state_q)
         ST_RUN: begin
            if (irq_take) begin
               mem_we    = 1'b1;
               mem_wdata = DW'(ip_q);
               st_push   = 1'b1;
               ien_d     = 1'b0;
               vec_d     = VEC_HW;
               state_d   = ST_VECRD;
            end else if (accept) begin
               if (is_br) begin
                  ip_d = br_ip;
               end else begin
                  case (op_code)
                     OPC_CALL: begin
                        mem_we    = 1'b1;
                        mem_wdata = DW'(ip_q + STEP2);
                        st_push   = 1'b1;
                        ip_d      = op_arg[AW-1:0];
                     end
                     OPC_RET, OPC_IRET: begin
                        st_pop   = 1'b1;
                        mem_re   = 1'b1;
                        mem_addr = sp_up;
                        state_d  = ST_RETLD;
                     end
                     OPC_INT: begin
                        mem_we    = 1'b1;
                        mem_wdata = DW'(ip_q + STEP2);
                        st_push   = 1'b1;
                        vec_d     = op_arg[AW-1:0];
                        state_d   = ST_VECRD;
                     end
                     OPC_PUSH: begin
                        mem_we    = 1'b1;
                        mem_wdata = push_data;
                        st_push   = 1'b1;
                        ip_d      = ip_q + STEP2;
                     end
                     OPC_PUSHF: begin
                        mem_we    = 1'b1;
                        mem_wdata = status_in;
                        st_push   = 1'b1;
                        ip_d      = ip_q + STEP1;
                     end
                     OPC_POP: begin
                        st_pop   = 1'b1;
                        mem_re   = 1'b1;
                        mem_addr = sp_up;
                        popf_d   = 1'b0;
                        ip_d     = ip_q + STEP2;
                        state_d  = ST_POPRD;
                     end
                     OPC_POPF: begin
                        st_pop   = 1'b1;
                        mem_re   = 1'b1;
                        mem_addr = sp_up;
                        popf_d   = 1'b1;
                        ip_d     = ip_q + STEP1;
                        state_d  = ST_POPRD;
                     end
                     OPC_STI: begin
                        ien_d = 1'b1;
                        ip_d  = ip_q + STEP1;
                     end
                     OPC_CLI: begin
                        ien_d = 1'b0;
                        ip_d  = ip_q + STEP1;
                     end
                     OPC_NOP: ip_d = ip_q + STEP1;
                     OPC_HALT: state_d = ST_HALT;
                     default: ip_d = ip_q + AW'(op_len);
                  endcase
               end
            end
         end
         ST_RETLD: begin
            ip_d    = mem_rdata[AW-1:0];
            state_d = ST_RUN;
         end
         ST_VECRD: begin
            mem_re   = 1'b1;
            mem_addr = vec_q;
            state_d  = ST_VECLD;
         end
         ST_VECLD: begin
            ip_d    = mem_rdata[AW-1:0];
            state_d = ST_RUN;
         end
         ST_POPRD: state_d = ST_RUN;
         ST_HALT:  state_d = ST_HALT;
         default:  state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         ip_q    <= IP_INIT;
         vec_q   <= VEC_HW;
         ien_q   <= 1'b0;
         popf_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         ip_q    <= ip_d;
         vec_q   <= vec_d;
         ien_q   <= ien_d;
         popf_q  <= popf_d;
      end
   end

   assign ip        = ip_q;
   assign int_en    = ien_q;
   assign halted    = (state_q == ST_HALT);
   assign pop_valid = (state_q == ST_POPRD);
   assign pop_flags = popf_q;
   assign pop_data  = mem_rdata;

endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          op_valid,
   input logic          op_ready,
   input logic [7:0]    op_code,
   input logic          flag_z,
   input logic          irq,
   input logic          mem_we,
   input logic          mem_re,
   input logic          pop_valid,
   input logic          pop_flags,
   input logic [AW-1:0] ip,
   input logic [AW-1:0] sp,
   input logic          int_en,
   input logic          halted
);
   logic acc;
   assign acc = op_valid && op_ready;

   always_comb begin
      if (rst_n) begin
         p_one_access_r13: assert (!(mem_we && mem_re));
      end
   end

   p_halt_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && $stable(ip) && $stable(sp) && !op_ready);

   p_push_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (op_code == 8'hE0 || op_code == 8'hEA) |=> sp == $past(sp) - AW'(1));

   p_jz_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_code == 8'hC1 && !flag_z |=> ip == $past(ip) + AW'(2));

   p_irq_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq && int_en && mem_we |=> !int_en);

   p_pop_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_code == 8'hE1 |=> pop_valid && !pop_flags);

endmodule

bind flow_seq flow_seq_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_ready  (op_ready),
   .op_code   (op_code),
   .flag_z    (flag_z),
   .irq       (irq),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .pop_valid (pop_valid),
   .pop_flags (pop_flags),
   .ip        (ip),
   .sp        (sp),
   .int_en    (int_en),
   .halted    (halted)
);

// File: tb/flow_seq_test.sv
module flow_seq_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       op_valid, op_ready;
   logic [7:0] op_code, op_arg;
   logic [1:0] op_len;
   logic       flag_z, flag_s, flag_o;
   logic [7:0] push_data, status_in;
   logic       irq;
   logic [7:0] mem_addr, mem_wdata, mem_rdata;
   logic       mem_we, mem_re;
   logic       pop_valid, pop_flags;
   logic [7:0] pop_data, ip, sp;
   logic       int_en, halted;

   always #(CLK_PERIOD/2) clk = ~clk;

   flow_seq uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_code(op_code), .op_arg(op_arg), .op_len(op_len),
      .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
      .push_data(push_data), .status_in(status_in), .irq(irq),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .pop_valid(pop_valid), .pop_flags(pop_flags), .pop_data(pop_data),
      .ip(ip), .sp(sp), .int_en(int_en), .halted(halted)
   );

   logic [7:0] ram [256];
   always @(posedge clk) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= ram[mem_addr];
   end

   int vecs = 0;
   int errs = 0;
   logic [7:0] e_ip, e_sp;
   logic       e_ien;
   logic       got_pop, got_popf;
   logic [7:0] got_data;

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic state_check(string tag);
      check({tag, " ip"}, 16'(ip), 16'(e_ip));
      check({tag, " sp"}, 16'(sp), 16'(e_sp));
      check({tag, " int_en"}, 16'(int_en), 16'(e_ien));
   endtask

   task automatic do_reset();
      rst_n = 1'b0; op_valid = 1'b0; irq = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      e_ip = 8'h00; e_sp = 8'hBF; e_ien = 1'b0;
      @(negedge clk);
   endtask

   task automatic issue(logic [7:0] c, logic [7:0] a, logic [1:0] l);
      int n;
      n = 0;
      while (!op_ready && !halted && n < 50) begin @(negedge clk); n++; end
      op_code = c; op_arg = a; op_len = l; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      got_pop = 1'b0;
      n = 0;
      while (!op_ready && !halted && n < 50) begin
         if (pop_valid) begin
            got_pop = 1'b1; got_popf = pop_flags; got_data = pop_data;
         end
         @(negedge clk);
         n++;
      end
      if (n >= 50) check("issue timeout", 16'd1, 16'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      logic [7:0] base_sp, base_ip;
      for (int i = 0; i < 256; i++) ram[i] = 8'h00;
      op_code = 8'hFF; op_arg = 8'h00; op_len = 2'd1;
      flag_z = 1'b0; flag_s = 1'b0; flag_o = 1'b0;
      push_data = 8'h00; status_in = 8'h00;
      do_reset();

      // R1: reset state
      state_check("R1 reset");
      check("R1 halted", 16'(halted), 16'd0);
      check("R1 op_ready", 16'(op_ready), 16'd1);

      // R2 and R12: every displacement of the unconditional jump, ip wraps
      for (int d = 0; d < 256; d++) begin
         issue(8'hC0, 8'(d), 2'd2);
         e_ip = e_ip + 8'(d);
         state_check("R2 R12 jmp");
      end

      // R3: each conditional code under every flag combination
      for (int c = 1; c <= 6; c++) begin
         for (int f = 0; f < 8; f++) begin
            logic [2:0] fv;
            logic       tk;
            logic [7:0] dsp;
            fv = 3'(f);
            flag_z = fv[0]; flag_s = fv[1]; flag_o = fv[2];
            tk = (c % 2 == 1) ? fv[(c-1)/2] : !fv[(c-1)/2];
            dsp = (f % 2 == 0) ? 8'h13 : 8'hF6;
            issue(8'hC0 + 8'(c), dsp, 2'd2);
            e_ip = tk ? e_ip + dsp : e_ip + 8'd2;
            state_check("R3 cond");
         end
      end
      flag_z = 1'b0; flag_s = 1'b0; flag_o = 1'b0;

      // R9: enable/disable, no-op and plain instructions of each length
      issue(8'hFC, 8'h00, 2'd1); e_ip = e_ip + 1; e_ien = 1'b1; state_check("R9 sti");
      issue(8'hFD, 8'h00, 2'd1); e_ip = e_ip + 1; e_ien = 1'b0; state_check("R9 cli");
      issue(8'hFF, 8'h00, 2'd1); e_ip = e_ip + 1; state_check("R9 nop");
      for (int l = 1; l < 4; l++) begin
         issue(8'hA0 + 8'(l), 8'h55, 2'(l));
         e_ip = e_ip + 8'(l);
         state_check("R9 plain");
      end

      // R4 and R5: nested calls then returns
      for (int k = 0; k < 5; k++) begin
         base_ip = e_ip; base_sp = e_sp;
         issue(8'hCA, 8'h40 + 8'(k * 16), 2'd2);
         check("R4 call stack byte", 16'(ram[base_sp]), 16'(base_ip + 8'd2));
         e_sp = e_sp - 1; e_ip = 8'h40 + 8'(k * 16);
         state_check("R4 call");
      end
      for (int k = 4; k >= 0; k--) begin
         issue(8'hCB, 8'h00, 2'd1);
         e_sp = e_sp + 1; e_ip = ram[e_sp];
         state_check("R5 ret");
      end

      // R13: return keeps op_ready low for its second cycle
      issue(8'hCA, 8'h70, 2'd2); e_sp = e_sp - 1; e_ip = 8'h70;
      @(negedge clk);
      op_code = 8'hCB; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check("R13 ready low in ret", 16'(op_ready), 16'd0);
      @(negedge clk);
      e_sp = e_sp + 1; e_ip = ram[e_sp];
      state_check("R13 R5 ret done");

      // R7 and R8: push bytes and flags, pop them back in reverse
      for (int k = 0; k < 4; k++) begin
         base_sp = e_sp;
         push_data = 8'h30 + 8'(k * 7);
         issue(8'hE0, 8'h00, 2'd2);
         check("R7 push byte", 16'(ram[base_sp]), 16'(8'h30 + 8'(k * 7)));
         e_sp = e_sp - 1; e_ip = e_ip + 2;
         state_check("R7 push");
      end
      status_in = 8'hA5; base_sp = e_sp;
      issue(8'hEA, 8'h00, 2'd1);
      check("R7 pushf byte", 16'(ram[base_sp]), 16'hA5);
      e_sp = e_sp - 1; e_ip = e_ip + 1;
      state_check("R7 pushf");
      issue(8'hEB, 8'h00, 2'd1);
      check("R8 popf strobe", 16'({got_pop, got_popf}), 16'b11);
      check("R8 popf data", 16'(got_data), 16'hA5);
      e_sp = e_sp + 1; e_ip = e_ip + 1;
      state_check("R8 popf");
      for (int k = 3; k >= 0; k--) begin
         issue(8'hE1, 8'h00, 2'd2);
         check("R8 pop strobe", 16'({got_pop, got_popf}), 16'b10);
         check("R8 pop data", 16'(got_data), 16'(8'h30 + 8'(k * 7)));
         e_sp = e_sp + 1; e_ip = e_ip + 2;
         state_check("R8 pop");
      end

      // R6 and R5: software interrupt and interrupt return, enable untouched
      issue(8'hFC, 8'h00, 2'd1); e_ip = e_ip + 1; e_ien = 1'b1;
      ram[8'h40] = 8'h77;
      base_ip = e_ip; base_sp = e_sp;
      issue(8'hCC, 8'h40, 2'd2);
      check("R6 int stack byte", 16'(ram[base_sp]), 16'(base_ip + 8'd2));
      e_sp = e_sp - 1; e_ip = 8'h77;
      state_check("R6 int");
      issue(8'hCD, 8'h00, 2'd1);
      e_sp = e_sp + 1; e_ip = base_ip + 8'd2;
      state_check("R5 iret");

      // R10: enabled request taken at a boundary, vector from address 02
      ram[8'h02] = 8'h90;
      @(negedge clk);
      irq = 1'b1;
      base_ip = e_ip; base_sp = e_sp;
      @(negedge clk);
      check("R10 ready low on entry", 16'(op_ready), 16'd0);
      repeat (3) @(negedge clk);
      irq = 1'b0;
      check("R10 saved ip", 16'(ram[base_sp]), 16'(base_ip));
      e_sp = e_sp - 1; e_ip = 8'h90; e_ien = 1'b0;
      state_check("R10 entry");
      issue(8'hCD, 8'h00, 2'd1);
      e_sp = e_sp + 1; e_ip = base_ip;
      state_check("R10 R5 iret keeps I clear");

      // R10: request ignored while disabled, taken once enabled
      irq = 1'b1;
      issue(8'hFF, 8'h00, 2'd1); e_ip = e_ip + 1;
      state_check("R10 masked");
      base_sp = e_sp;
      issue(8'hFC, 8'h00, 2'd1);
      irq = 1'b0;
      check("R10 next instr saved", 16'(ram[base_sp]), 16'(e_ip + 8'd1));
      e_sp = e_sp - 1; e_ip = 8'h90; e_ien = 1'b0;
      state_check("R10 taken after sti");

      // R12: stack pointer wraps through 00 and back, order preserved
      do_reset();
      for (int k = 0; k < 193; k++) begin
         push_data = 8'(k * 3 + 1);
         issue(8'hE0, 8'h00, 2'd2);
      end
      e_sp = 8'hBF - 8'd193; e_ip = 8'(193 * 2);
      state_check("R12 sp wrap down");
      for (int k = 192; k >= 0; k--) begin
         issue(8'hE1, 8'h00, 2'd2);
         if (got_data !== 8'(k * 3 + 1))
            check("R12 wrap pop data", 16'(got_data), 16'(8'(k * 3 + 1)));
      end
      check("R12 wrap pops all", 16'(got_data), 16'h01);
      e_sp = 8'hBF; e_ip = e_ip + 8'(193 * 2);
      state_check("R12 sp wrap up");

      // R11: halt freezes everything, only reset restarts
      issue(8'hFC, 8'h00, 2'd1); e_ip = e_ip + 1; e_ien = 1'b1;
      issue(8'h00, 8'h00, 2'd1);
      check("R11 halted", 16'(halted), 16'd1);
      irq = 1'b1; op_code = 8'hFF; op_valid = 1'b1;
      repeat (6) @(negedge clk);
      op_valid = 1'b0; irq = 1'b0;
      state_check("R11 frozen");
      check("R11 ready low", 16'(op_ready), 16'd0);
      do_reset();
      state_check("R11 R1 after reset");
      check("R11 R1 halt cleared", 16'(halted), 16'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule